// File: doc/BRIEF.md
# Board Control Register File

This block is the control register file of a development board, seen by the processor as a 32-bit memory-mapped window on a simple synchronous bus. It has a handful of small registers: an 8-bit LED bar, a break/reset byte, a general-purpose output byte and a group that bit-bangs an I2C link to a serial EEPROM. It also has an eight-character text display and a soft-reset trigger. The LED bits and the display characters leave the block as parallel outputs. The I2C clock and data levels are driven straight from a software-written register, and the EEPROM data line is sampled back on read.

Software fills the display in one of two ways. It can write a 32-bit word, which the block turns into eight uppercase hexadecimal ASCII digits. It can also write the characters one at a time through eight separate slots. A system reset request is raised for one cycle only when a fixed key value is written to the soft-reset register. This keeps a stray store from resetting the board.

Top module: `board_ctrl_regs`

## Requirements
- R1: After reset the LED bar is 0x00, break 0x0A, GP out 0x00, I2C output enable 0x0, I2C out 0x3 (clock and data pins high), I2C select 0x1, every display character is 0x20, and no reset request is active.
- R2: Only address bits [19:0] are decoded. A read of any offset without a readable register returns 0, and a write to an offset without a writable register changes nothing. The switch (0x200) and jumper (0x210) offsets always read 0.
- R3: The status offset 0x208 reads 0x12 when the BIG_ENDIAN parameter is 1 and 0x10 when it is 0.
- R4: A write to 0x408 keeps data bits [7:0] as the LED bar, which is readable at 0x408 and drives `led_bar`.
- R5: A write to 0x410 sets all display characters from the data word. Character k (bits [8k+7:8k] of `disp_chars`) becomes the ASCII code of nibble data[31-4k:28-4k], using '0'..'9' (0x30..0x39) and 'A'..'F' (0x41..0x46).
- R6: A write to offset 0x418 + 8k (k = 0..7) sets character k to data bits [7:0] and leaves the other characters unchanged.
- R7: A write of exactly 0x00000042 to 0x500 makes `sys_reset_req` high for exactly the following cycle. Any other value leaves it low.
- R8: Break (0x508) and GP out (0xA00) keep 8 bits, I2C output enable (0xB08) keeps 2 bits and I2C select (0xB18) keeps 1 bit. Each reads back zero-extended.
- R9: A write to 0xB10 stores the full 32-bit word, readable at 0xB10. Bit 1 drives `eeprom_scl` and bit 0 drives `eeprom_sda`. The pins change only on such a write.
- R10: A read of 0xB00 returns 0x2 with bit 0 replaced by the level of `eeprom_sda_in` in the read cycle.
- R11: A read of 0xA08 returns the I2C out word while select is 1, and 0 while select is 0.
- R12: Read data appears with `bus_rvalid` high in the cycle after a read request. `bus_rvalid` is low after writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_req | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only [19:0] decoded |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| led_bar | output | 8 | LED bar bits |
| disp_chars | output | DATA_W*2 | Display characters, character k at [8k+7:8k] |
| sys_reset_req | output | 1 | One-cycle system reset request |
| eeprom_scl | output | 1 | I2C clock level toward the EEPROM |
| eeprom_sda | output | 1 | I2C data level toward the EEPROM |
| eeprom_sda_in | input | 1 | Sampled EEPROM data line |

## Verification
The bench sweeps every word offset below 0xC00. It first writes all-ones to each offset that has no writable register, then reads every offset and compares against an arithmetic model. A decoder that aliased a neighbour, or decoded the display slots too loosely, would either corrupt a register or return non-zero data from a hole. All 256 byte values go to the soft-reset offset. A comparator that tested only the low nibble, or that stretched the pulse, would raise the request on a wrong key or for two cycles. The hex word tests use patterns that between them place every nibble value in every position. A converter with the wrong letter offset or a reversed nibble order shows wrong characters. The select and EEPROM input tests flip the select bit and the input pin, so a mux that ignored either one returns a stale value.

// File: rtl/bcr_pkg.sv
// Package: shared constants, decode types and the hex-to-ASCII helper
// for the board control register file. Offsets are 20-bit byte offsets.
package bcr_pkg;

    localparam int OFFS_W = 20;

    localparam logic [OFFS_W-1:0] OFF_SWITCH  = 20'h00200;
    localparam logic [OFFS_W-1:0] OFF_STATUS  = 20'h00208;
    localparam logic [OFFS_W-1:0] OFF_JUMPER  = 20'h00210;
    localparam logic [OFFS_W-1:0] OFF_LEDBAR  = 20'h00408;
    localparam logic [OFFS_W-1:0] OFF_HEXWORD = 20'h00410;
    localparam logic [OFFS_W-1:0] OFF_CHAR0   = 20'h00418;
    localparam int                CHAR_STEP   = 8;
    localparam logic [OFFS_W-1:0] OFF_SOFTRST = 20'h00500;
    localparam logic [OFFS_W-1:0] OFF_BREAK   = 20'h00508;
    localparam logic [OFFS_W-1:0] OFF_GPOUT   = 20'h00A00;
    localparam logic [OFFS_W-1:0] OFF_GPIN    = 20'h00A08;
    localparam logic [OFFS_W-1:0] OFF_I2CIN   = 20'h00B00;
    localparam logic [OFFS_W-1:0] OFF_I2COE   = 20'h00B08;
    localparam logic [OFFS_W-1:0] OFF_I2COUT  = 20'h00B10;
    localparam logic [OFFS_W-1:0] OFF_I2CSEL  = 20'h00B18;

    localparam logic [7:0] SOFTRST_KEY = 8'h42;
    localparam logic [7:0] BREAK_INIT  = 8'h0A;
    localparam logic [7:0] CHAR_BLANK  = 8'h20;

    // One flag per writable scalar register (display slots are separate).
    typedef struct packed {
        logic led;
        logic hexword;
        logic softrst;
        logic brk;
        logic gpout;
        logic i2c_oe;
        logic i2c_out;
        logic i2c_sel;
    } wr_hits_t;

    // ASCII code of one hexadecimal digit, uppercase letters.
    function automatic logic [7:0] hex_ascii(input logic [3:0] nib);
        return (nib < 4'd10) ? (8'h30 + {4'h0, nib}) : (8'h37 + {4'h0, nib});
    endfunction

endpackage

// File: rtl/bcr_decode.sv
// Write decoder: turns a bus write into one-hot register strobes.
// Assumes full-word accesses; an offset must match exactly to hit.
module bcr_decode
    import bcr_pkg::*;
#(
    parameter int NUM_CHARS = 8
) (
    input  logic                 wr_en,
    input  logic [OFFS_W-1:0]    offset,
    output wr_hits_t             hits,
    output logic [NUM_CHARS-1:0] char_hits
);

    // Scalar register strobes.
    always_comb begin
        hits         = '0;
        hits.led     = wr_en && (offset == OFF_LEDBAR);
        hits.hexword = wr_en && (offset == OFF_HEXWORD);
        hits.softrst = wr_en && (offset == OFF_SOFTRST);
        hits.brk     = wr_en && (offset == OFF_BREAK);
        hits.gpout   = wr_en && (offset == OFF_GPOUT);
        hits.i2c_oe  = wr_en && (offset == OFF_I2COE);
        hits.i2c_out = wr_en && (offset == OFF_I2COUT);
        hits.i2c_sel = wr_en && (offset == OFF_I2CSEL);
    end

    // One strobe per display character slot.
    for (genvar k = 0; k < NUM_CHARS; k++) begin : g_slot
        localparam logic [OFFS_W-1:0] SLOT_OFF = OFF_CHAR0 + OFFS_W'(k * CHAR_STEP);
        assign char_hits[k] = wr_en && (offset == SLOT_OFF);
    end

endmodule

// File: rtl/bcr_display.sv
// Display buffer: NUM_CHARS eight-bit characters. A word write fills all
// characters with hex digits (character 0 = most significant nibble); a slot
// write sets one character. Assumes DATA_W == 4 * NUM_CHARS.
module bcr_display
    import bcr_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int NUM_CHARS = DATA_W / 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_word,
    input  logic [NUM_CHARS-1:0]   wr_char,
    input  logic [DATA_W-1:0]      wdata,
    output logic [8*NUM_CHARS-1:0] chars
);

    for (genvar k = 0; k < NUM_CHARS; k++) begin : g_char
        localparam int NIB_LO = 4 * (NUM_CHARS - 1 - k);
        // Character k register: blank on reset, hex digit or raw byte on write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chars[8*k +: 8] <= CHAR_BLANK;
            else if (wr_word)
                chars[8*k +: 8] <= hex_ascii(wdata[NIB_LO +: 4]);
            else if (wr_char[k])
                chars[8*k +: 8] <= wdata[7:0];
        end
    end

endmodule

// File: rtl/bcr_i2c.sv
// Bit-banged I2C group: output enable (2 bits), full-word output register
// whose bits 1 and 0 drive clock and data, and a 1-bit input select.
// Pin levels change only when the output register is written.
module bcr_i2c #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_oe,
    input  logic              wr_out,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [1:0]        oe,
    output logic [DATA_W-1:0] out_word,
    output logic              sel,
    output logic              scl,
    output logic              sda
);

    // Control registers with their reset values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe       <= 2'b00;
            out_word <= DATA_W'(3);
            sel      <= 1'b1;
        end else begin
            if (wr_oe)  oe       <= wdata[1:0];
            if (wr_out) out_word <= wdata;
            if (wr_sel) sel      <= wdata[0];
        end
    end

    assign scl = out_word[1];
    assign sda = out_word[0];

endmodule

// File: rtl/board_ctrl_regs.sv
// Board control register file top. Decodes address bits [19:0] of a simple
// synchronous bus; reads return data one cycle later with bus_rvalid.
// Byte enables are not supported: every access is a full word.
module board_ctrl_regs
    import bcr_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter bit BIG_ENDIAN = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_req,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    output logic [7:0]          led_bar,
    output logic [DATA_W*2-1:0] disp_chars,
    output logic                sys_reset_req,
    output logic                eeprom_scl,
    output logic                eeprom_sda,
    input  logic                eeprom_sda_in
);

    localparam int NUM_CHARS = DATA_W / 4;
    localparam logic [DATA_W-1:0] STATUS_VAL = BIG_ENDIAN ? DATA_W'(8'h12) : DATA_W'(8'h10);
    localparam logic [DATA_W-1:0] I2C_IN_INIT = DATA_W'(3);

    logic [OFFS_W-1:0]    offset;
    logic                 unused_addr_hi;
    wr_hits_t             hits;
    logic [NUM_CHARS-1:0] char_hits;
    logic [7:0]           brk_q, gpout_q;
    logic [1:0]           i2c_oe;
    logic [DATA_W-1:0]    i2c_out;
    logic                 i2c_sel;
    logic [DATA_W-1:0]    rd_mux;

    assign offset         = bus_addr[OFFS_W-1:0];
    assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFFS_W];

    bcr_decode #(.NUM_CHARS(NUM_CHARS)) u_decode (
        .wr_en     (bus_req && bus_we),
        .offset    (offset),
        .hits      (hits),
        .char_hits (char_hits)
    );

    bcr_display #(.DATA_W(DATA_W), .NUM_CHARS(NUM_CHARS)) u_display (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_word (hits.hexword),
        .wr_char (char_hits),
        .wdata   (bus_wdata),
        .chars   (disp_chars)
    );

    bcr_i2c #(.DATA_W(DATA_W)) u_i2c (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_oe    (hits.i2c_oe),
        .wr_out   (hits.i2c_out),
        .wr_sel   (hits.i2c_sel),
        .wdata    (bus_wdata),
        .oe       (i2c_oe),
        .out_word (i2c_out),
        .sel      (i2c_sel),
        .scl      (eeprom_scl),
        .sda      (eeprom_sda)
    );

    // Byte-wide registers: LED bar, break and GP out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            led_bar <= 8'h00;
            brk_q   <= BREAK_INIT;
            gpout_q <= 8'h00;
        end else begin
            if (hits.led)   led_bar <= bus_wdata[7:0];
            if (hits.brk)   brk_q   <= bus_wdata[7:0];
            if (hits.gpout) gpout_q <= bus_wdata[7:0];
        end
    end

    // Soft reset: one-cycle request on the exact key value.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sys_reset_req <= 1'b0;
        else
            sys_reset_req <= hits.softrst && (bus_wdata == DATA_W'(SOFTRST_KEY));
    end

    // Read data selection by offset; holes read zero.
    always_comb begin
        case (offset)
            OFF_SWITCH, OFF_JUMPER: rd_mux = '0;
            OFF_STATUS:             rd_mux = STATUS_VAL;
            OFF_LEDBAR:             rd_mux = DATA_W'(led_bar);
            OFF_BREAK:              rd_mux = DATA_W'(brk_q);
            OFF_GPOUT:              rd_mux = DATA_W'(gpout_q);
            OFF_GPIN:               rd_mux = i2c_sel ? i2c_out : '0;
            OFF_I2CIN:              rd_mux = {I2C_IN_INIT[DATA_W-1:1], eeprom_sda_in};
            OFF_I2COE:              rd_mux = DATA_W'(i2c_oe);
            OFF_I2COUT:             rd_mux = i2c_out;
            OFF_I2CSEL:             rd_mux = DATA_W'(i2c_sel);
            default:                rd_mux = '0;
        endcase
    end

    // Read response register: data plus valid one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_req && !bus_we;
            if (bus_req && !bus_we)
                bus_rdata <= rd_mux;
        end
    end

endmodule

// File: rtl/bcr_checker.sv
// Checker bound to board_ctrl_regs: temporal properties on its ports.
module bcr_checker #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_req,
    input logic                bus_we,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic [DATA_W-1:0]   bus_wdata,
    input logic [DATA_W-1:0]   bus_rdata,
    input logic                bus_rvalid,
    input logic [7:0]          led_bar,
    input logic [DATA_W*2-1:0] disp_chars,
    input logic                sys_reset_req,
    input logic                eeprom_scl,
    input logic                eeprom_sda
);

    logic [19:0] off;
    logic        wr, rd, disp_wr;
    assign off     = bus_addr[19:0];
    assign wr      = bus_req && bus_we;
    assign rd      = bus_req && !bus_we;
    assign disp_wr = wr && ((off == 20'h00410) ||
                     ((off >= 20'h00418) && (off <= 20'h00450) && (off[2:0] == 3'b000)));

    assert_rvalid_after_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> bus_rvalid);
    assert_rvalid_needs_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(rd));
    assert_hole_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && off == 20'h00C00) |=> (bus_rdata == '0));
    assert_reset_req_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(wr && off == 20'h00500 && bus_wdata == DATA_W'(8'h42)));
    assert_reset_req_wrong_key_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && off == 20'h00500 && bus_wdata != DATA_W'(8'h42)) |=> !sys_reset_req);
    assert_led_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(led_bar) |-> $past(wr && off == 20'h00408));
    assert_disp_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_chars) |-> $past(disp_wr));
    assert_pins_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(eeprom_scl) || !$stable(eeprom_sda)) |-> $past(wr && off == 20'h00B10));

endmodule

bind board_ctrl_regs bcr_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_bcr_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_req       (bus_req),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .bus_rdata     (bus_rdata),
    .bus_rvalid    (bus_rvalid),
    .led_bar       (led_bar),
    .disp_chars    (disp_chars),
    .sys_reset_req (sys_reset_req),
    .eeprom_scl    (eeprom_scl),
    .eeprom_sda    (eeprom_sda)
);

// File: tb/test_board_ctrl_regs.sv
module test_board_ctrl_regs;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;
    localparam logic [31:0] BASE = 32'h1F000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [31:0] bus_addr = '0, bus_wdata = '0;
    logic [31:0] bus_rdata, be_rdata;
    logic        bus_rvalid, be_rvalid;
    logic [7:0]  led_bar, be_led;
    logic [63:0] disp_chars, be_disp;
    logic        sys_reset_req, be_rst;
    logic        eeprom_scl, eeprom_sda, be_scl, be_sda;
    logic        eeprom_sda_in = 1'b0;

    int n_checks = 0;
    int n_fails  = 0;

    // Bench model of the registers
    logic [7:0]  m_led = 8'h00, m_brk = 8'h0A, m_gp = 8'h00;
    logic [1:0]  m_oe = 2'b00;
    logic [31:0] m_out = 32'h3;
    logic        m_sel = 1'b1;
    logic [7:0]  m_disp [8];
    string       hexs = "0123456789ABCDEF";

    always #(CLK_PERIOD/2) clk = ~clk;

    board_ctrl_regs i_board_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .led_bar(led_bar), .disp_chars(disp_chars),
        .sys_reset_req(sys_reset_req), .eeprom_scl(eeprom_scl),
        .eeprom_sda(eeprom_sda), .eeprom_sda_in(eeprom_sda_in)
    );

    board_ctrl_regs #(.BIG_ENDIAN(1'b1)) i_board_ctrl_regs_be (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(be_rdata),
        .bus_rvalid(be_rvalid), .led_bar(be_led), .disp_chars(be_disp),
        .sys_reset_req(be_rst), .eeprom_scl(be_scl),
        .eeprom_sda(be_sda), .eeprom_sda_in(eeprom_sda_in)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] addr, output logic [31:0] data, output logic valid);
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = addr;
        @(negedge clk);
        data = bus_rdata; valid = bus_rvalid;
        bus_req = 1'b0;
    endtask

    function automatic logic [63:0] model_disp();
        logic [63:0] v;
        for (int k = 0; k < 8; k++) v[8*k +: 8] = m_disp[k];
        return v;
    endfunction

    function automatic logic [31:0] model_read(input logic [19:0] off);
        case (off)
            20'h00208: return 32'h10;
            20'h00408: return {24'h0, m_led};
            20'h00508: return {24'h0, m_brk};
            20'h00A00: return {24'h0, m_gp};
            20'h00A08: return m_sel ? m_out : 32'h0;
            20'h00B00: return 32'h2 | {31'h0, eeprom_sda_in};
            20'h00B08: return {30'h0, m_oe};
            20'h00B10: return m_out;
            20'h00B18: return {31'h0, m_sel};
            default:   return 32'h0;
        endcase
    endfunction

    function automatic bit is_writable(input logic [19:0] off);
        if (off == 20'h408 || off == 20'h410 || off == 20'h500 || off == 20'h508 ||
            off == 20'hA00 || off == 20'hB08 || off == 20'hB10 || off == 20'hB18)
            return 1'b1;
        if (off >= 20'h418 && off <= 20'h450 && off[2:0] == 3'b000)
            return 1'b1;
        return 1'b0;
    endfunction

    // Read every word offset below 0xC00 and compare with the model (R2 and others).
    task automatic sweep_map(input string req);
        logic [31:0] d;
        logic        v;
        for (int off = 0; off < 'hC00; off += 4) begin
            bus_read(BASE | off, d, v);
            check(req, {v, d}, {1'b1, model_read(20'(off))});
        end
    endtask

    task automatic hex_word(input logic [31:0] w);
        bus_write(BASE | 32'h410, w);
        for (int k = 0; k < 8; k++) m_disp[k] = hexs[(w >> (28 - 4*k)) & 32'hF];
        check("R5 hex word", disp_chars, model_disp());
    endtask

    initial begin
        logic [31:0] d;
        logic        v;
        for (int k = 0; k < 8; k++) m_disp[k] = 8'h20;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state on outputs and in the register map
        check("R1 led", led_bar, 8'h00);
        check("R1 display", disp_chars, {8{8'h20}});
        check("R1 pins", {eeprom_scl, eeprom_sda, sys_reset_req}, 3'b110);
        check("R12 idle rvalid", bus_rvalid, 1'b0);
        sweep_map("R1 reset map");

        // R3: status depends on configuration
        bus_read(BASE | 32'h208, d, v);
        check("R3 status little", d, 32'h10);
        check("R3 status big", be_rdata, 32'h12);

        // R4, R8: width masks
        bus_write(BASE | 32'h408, 32'hFFFFFF5A); m_led = 8'h5A;
        check("R4 led pins", led_bar, 8'h5A);
        check("R12 rvalid after write", bus_rvalid, 1'b0);
        bus_write(BASE | 32'h508, 32'h123456C3); m_brk = 8'hC3;
        bus_write(BASE | 32'hA00, 32'hABCDEF99); m_gp  = 8'h99;
        bus_write(BASE | 32'hB08, 32'hFFFFFFFF); m_oe  = 2'b11;
        bus_read(32'hABC00408, d, v);
        check("R2 upper address bits ignored", d, 32'h5A);

        // R9: full word stored, pins follow bits 1 and 0
        bus_write(BASE | 32'hB10, 32'hDEADBEE2); m_out = 32'hDEADBEE2;
        check("R9 pins scl=1 sda=0", {eeprom_scl, eeprom_sda}, 2'b10);
        bus_write(BASE | 32'hB10, 32'h00000001); m_out = 32'h1;
        check("R9 pins scl=0 sda=1", {eeprom_scl, eeprom_sda}, 2'b01);
        bus_write(BASE | 32'hB10, 32'h80000000); m_out = 32'h80000000;
        check("R9 pins scl=0 sda=0", {eeprom_scl, eeprom_sda}, 2'b00);

        // R11: GP input follows select
        bus_read(BASE | 32'hA08, d, v);
        check("R11 select on", d, 32'h80000000);
        bus_write(BASE | 32'hB18, 32'hFFFFFFFE); m_sel = 1'b0;
        bus_read(BASE | 32'hA08, d, v);
        check("R11 select off", d, 32'h0);
        bus_read(BASE | 32'hB18, d, v);
        check("R8 select width", d, 32'h0);
        bus_write(BASE | 32'hB18, 32'h3); m_sel = 1'b1;

        // R10: EEPROM input replaces bit 0
        eeprom_sda_in = 1'b1;
        bus_read(BASE | 32'hB00, d, v);
        check("R10 sda_in=1", d, 32'h3);
        eeprom_sda_in = 1'b0;
        bus_read(BASE | 32'hB00, d, v);
        check("R10 sda_in=0", d, 32'h2);

        // R5: every nibble value in every position
        hex_word(32'h01234567);
        hex_word(32'h89ABCDEF);
        hex_word(32'hFEDCBA98);
        hex_word(32'h76543210);
        for (int n = 0; n < 16; n++) hex_word(32'h11111111 * n);

        // R6: single character slots
        for (int k = 0; k < 8; k++) begin
            bus_write(BASE | (32'h418 + 8*k), 32'hFFFFFF00 | (8'h61 + k));
            m_disp[k] = 8'h61 + k;
            check("R6 slot write", disp_chars, model_disp());
        end

        // R7: soft reset only on the key, for one cycle
        for (int val = 0; val < 256; val++) begin
            bus_write(BASE | 32'h500, 32'(val));
            check("R7 request", sys_reset_req, (val == 'h42));
            @(negedge clk);
            check("R7 one cycle", sys_reset_req, 1'b0);
        end
        bus_write(BASE | 32'h500, 32'h00000142);
        check("R7 upper bits", sys_reset_req, 1'b0);

        // R2: writes to every non-writable offset change nothing
        for (int off = 0; off < 'hC00; off += 4)
            if (!is_writable(20'(off))) bus_write(BASE | off, 32'hFFFFFFFF);
        check("R2 display after hole writes", disp_chars, model_disp());
        check("R2 led after hole writes", led_bar, m_led);
        sweep_map("R2 map after hole writes");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule